// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Synchronous Memory

This block is the test access port of a synchronous memory device. A sixteen-state controller advances on each rising edge of the test clock under the mode-select input. A 3-bit instruction register, loaded through its own shift path, chooses one of three data registers to sit between the serial input and the serial output:

- a 1-bit bypass register;
- a 32-bit identification register;
- a boundary register whose width is set by a parameter and which samples the pad-input vector.

The instruction also decides whether the memory's data drivers are forced to high impedance. That decision reaches the core as `data_hiz`.

The controller states are:

| Branch | States |
| --- | --- |
| Common | TS_RESET (test-logic reset), TS_IDLE (run-test/idle) |
| Data | TS_DR_SEL, TS_DR_CAP, TS_DR_SHIFT, TS_DR_EXIT1, TS_DR_PAUSE, TS_DR_EXIT2, TS_DR_UPD |
| Instruction | TS_IR_SEL, TS_IR_CAP, TS_IR_SHIFT, TS_IR_EXIT1, TS_IR_PAUSE, TS_IR_EXIT2, TS_IR_UPD |

The transitions, written as mode-select value → next state, are:

| State | mode-select 1 | mode-select 0 |
| --- | --- | --- |
| RESET | RESET | IDLE |
| IDLE | DR_SEL | IDLE |
| DR_SEL | IR_SEL | DR_CAP |
| DR_CAP | DR_EXIT1 | DR_SHIFT |
| DR_SHIFT | DR_EXIT1 | DR_SHIFT |
| DR_EXIT1 | DR_UPD | DR_PAUSE |
| DR_PAUSE | DR_EXIT2 | DR_PAUSE |
| DR_EXIT2 | DR_UPD | DR_SHIFT |
| DR_UPD | DR_SEL | IDLE |
| IR_SEL | RESET | IR_CAP |
| IR_CAP, IR_SHIFT, IR_EXIT1, IR_PAUSE, IR_EXIT2, IR_UPD | as the DR branch, with IR in place of DR | as the DR branch, with IR in place of DR |

The instruction set departs from the usual boundary-scan conventions in two ways:

- Two instructions force the data outputs to high impedance: the external-test code and the sample-with-high-impedance code.
- The sample code captures the pads but never preloads anything. The Update-DR state therefore never changes any register or output.

Top module: `scan_tap`

## Requirements
- R1: The controller moves between its sixteen states on each rising `tck` edge exactly as the transition table in this brief gives, including the pause and exit2 loops of both branches.
- R2: Five consecutive rising edges with `tms` high bring the controller to TS_RESET from any state. Driving `trst_n` low forces TS_RESET at once, without waiting for a clock edge.
- R3: In TS_RESET, and under `trst_n`, the active instruction becomes the identification code 001 and `data_hiz` is released (0).
- R4: In TS_IR_CAP the instruction shift stage loads 001. In TS_IR_SHIFT it shifts one place towards bit 0 per edge, with `tdi` entering bit 2 and bit 0 leaving first.
- R5: A shifted instruction becomes active only on the falling `tck` edge while in TS_IR_UPD. Until then `data_hiz` keeps the value set by the previous instruction.
- R6: `tdo` changes only on falling `tck` edges. `tdo_oe` is 1 exactly during TS_IR_SHIFT and TS_DR_SHIFT and is 0 in every other state and under reset.
- R7: Code 111 and the unused codes 011, 101 and 110 select the 1-bit bypass register. It captures 0 and then delays `tdi` by one shift.
- R8: Code 001 selects the 32-bit identification register. It captures `ID_VALUE` with bit 0 forced to 1 and shifts bit 0 out first.
- R9: Codes 000, 010 and 100 select the boundary register. It captures `pad_in[k]` into position k and shifts position 0 out first.
- R10: `data_hiz` is 1 while the active instruction is 000 or 010, and 0 under every other code.
- R11: Passing through TS_DR_UPD has no effect under any instruction: `data_hiz` is unchanged and the next capture again reflects the pads, with nothing preloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pad_in | input | BSR_W | Pad values sampled by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` is driven; low means high impedance |
| data_hiz | output | 1 | Forces the memory data drivers to high impedance |

## Verification
The bench builds the block with a 5-bit boundary register. This keeps every pad position short enough to follow bit by bit when a pause is inserted mid-shift.

The bench also sets an identification value whose bit 0 is 0. Any design that passes the raw parameter through, instead of forcing bit 0 to 1, is therefore visible in the serial output.

All eight instruction codes are loaded. The five-high escape is tried from inside the data shift loop and from the instruction pause state, and the asynchronous reset is applied while high impedance is forced.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_DR_SEL, TS_DR_CAP, TS_DR_SHIFT, TS_DR_EXIT1,
        TS_DR_PAUSE, TS_DR_EXIT2, TS_DR_UPD,
        TS_IR_SEL, TS_IR_CAP, TS_IR_SHIFT, TS_IR_EXIT1,
        TS_IR_PAUSE, TS_IR_EXIT2, TS_IR_UPD
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_BSR,
        PATH_ID,
        PATH_BYP
    } dr_path_t;

    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [OP_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [OP_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [OP_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [OP_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [OP_W-1:0] OP_CAPTURE = 3'b001;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t state_q;
    tap_state_t state_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= TS_RESET;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     state_d = tms ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   state_d = tms ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   state_d = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: state_d = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: state_d = tms ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: state_d = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: state_d = tms ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   state_d = tms ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   state_d = tms ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   state_d = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: state_d = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: state_d = tms ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: state_d = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: state_d = tms ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   state_d = tms ? TS_DR_SEL   : TS_IDLE;
            default:     state_d = TS_RESET;
        endcase
    end

    assign state = state_q;

    // Saturating count of consecutive high mode-select samples, for checking only
    logic [2:0] ones_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          ones_q <= 3'd0;
        else if (!tms)        ones_q <= 3'd0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (state_q == TS_RESET)); // R2
    AST_SHIFT_DR_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == TS_DR_SHIFT && !tms) |=> (state_q == TS_DR_SHIFT)); // R1

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    output logic       ir_lsb,
    output dr_path_t   path,
    output logic       force_hiz
);

    logic [OP_W-1:0] sh_q;
    logic [OP_W-1:0] op_q;

    // Capture and shift stage, rising edge
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                   sh_q <= '0;
        else if (state == TS_IR_CAP)   sh_q <= OP_CAPTURE;
        else if (state == TS_IR_SHIFT) sh_q <= {tdi, sh_q[OP_W-1:1]};
    end

    // Active instruction, falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                 op_q <= OP_IDCODE;
        else if (state == TS_RESET)  op_q <= OP_IDCODE;
        else if (state == TS_IR_UPD) op_q <= sh_q;
    end

    always_comb begin
        path      = PATH_BYP;
        force_hiz = 1'b0;
        unique case (op_q)
            OP_EXTEST:  begin path = PATH_BSR; force_hiz = 1'b1; end
            OP_SAMPLEZ: begin path = PATH_BSR; force_hiz = 1'b1; end
            OP_SAMPLE:  path = PATH_BSR;
            OP_IDCODE:  path = PATH_ID;
            default:    path = PATH_BYP;
        endcase
    end

    assign ir_lsb = sh_q[0];

    AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_IR_CAP) |=> (sh_q == OP_CAPTURE)); // R4
    AST_OP_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_IR_UPD && state != TS_RESET) |-> $stable(op_q)); // R5

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BSR_W    = 16,
    parameter logic [31:0] ID_VALUE = 32'h0A6B_4C2D
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_state_t       state,
    input  dr_path_t         path,
    input  logic [BSR_W-1:0] pad_in,
    output logic             dr_lsb
);

    localparam int ID_W = 32;
    localparam logic [ID_W-1:0] ID_CAPT = ID_VALUE | 32'h1;

    logic             byp_q;
    logic [ID_W-1:0]  id_q;
    logic [BSR_W-1:0] bsr_q;

    wire cap = (state == TS_DR_CAP);
    wire shf = (state == TS_DR_SHIFT);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                          byp_q <= 1'b0;
        else if (path == PATH_BYP && cap)     byp_q <= 1'b0;
        else if (path == PATH_BYP && shf)     byp_q <= tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                          id_q <= '0;
        else if (path == PATH_ID && cap)      id_q <= ID_CAPT;
        else if (path == PATH_ID && shf)      id_q <= {tdi, id_q[ID_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                          bsr_q <= '0;
        else if (path == PATH_BSR && cap)     bsr_q <= pad_in;
        else if (path == PATH_BSR && shf)     bsr_q <= {tdi, bsr_q[BSR_W-1:1]};
    end

    always_comb begin
        unique case (path)
            PATH_BSR: dr_lsb = bsr_q[0];
            PATH_ID:  dr_lsb = id_q[0];
            default:  dr_lsb = byp_q;
        endcase
    end

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && path == PATH_BYP) |=> (byp_q == 1'b0)); // R7
    AST_ID_LSB_SET: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && path == PATH_ID) |=> id_q[0]); // R8

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int          BSR_W    = 16,
    parameter logic [31:0] ID_VALUE = 32'h0A6B_4C2D
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pad_in,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             data_hiz
);

    tap_state_t state;
    dr_path_t   path;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       force_hiz;
    logic       tdo_q;
    logic       oe_q;

    scan_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    scan_tap_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .state     (state),
        .ir_lsb    (ir_lsb),
        .path      (path),
        .force_hiz (force_hiz)
    );

    scan_tap_dr #(
        .BSR_W    (BSR_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (state),
        .path   (path),
        .pad_in (pad_in),
        .dr_lsb (dr_lsb)
    );

    // Serial output, falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= (state == TS_IR_SHIFT) || (state == TS_DR_SHIFT);
            if (state == TS_IR_SHIFT)      tdo_q <= ir_lsb;
            else if (state == TS_DR_SHIFT) tdo_q <= dr_lsb;
        end
    end

    assign tdo      = tdo_q;
    assign tdo_oe   = oe_q;
    assign data_hiz = force_hiz;

    AST_TDO_QUIET_OUTSIDE_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_IR_SHIFT && state != TS_DR_SHIFT) |-> !tdo_oe); // R6
    AST_HIZ_RELEASED_IN_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_RESET) |-> !data_hiz); // R3

endmodule

// File: tb/scan_tap_tb.sv
module scan_tap_tb_top;

    localparam int          BW  = 5;
    localparam logic [31:0] IDV = 32'h5A3C_9E10;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BW-1:0] pad_in = '0;
    logic          tdo, tdo_oe, data_hiz;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #10 tck = ~tck;

    scan_tap #(.BSR_W(BW), .ID_VALUE(IDV)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pad_in(pad_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .data_hiz(data_hiz)
    );

    // Behavioural reference model
    int          m_st;
    bit [2:0]    m_irsh, m_ir;
    bit          m_byp, m_tdo, m_oe;
    bit [31:0]   m_id;
    bit [BW-1:0] m_bsr;
    bit          outq[$];

    function automatic int nxt(int s, bit m);
        case (s)
            0: return m ? 0 : 1;    1: return m ? 2 : 1;
            2: return m ? 9 : 3;    3: return m ? 5 : 4;
            4: return m ? 5 : 4;    5: return m ? 8 : 6;
            6: return m ? 7 : 6;    7: return m ? 8 : 4;
            8: return m ? 2 : 1;    9: return m ? 0 : 10;
            10: return m ? 12 : 11; 11: return m ? 12 : 11;
            12: return m ? 15 : 13; 13: return m ? 14 : 13;
            14: return m ? 15 : 11; default: return m ? 2 : 1;
        endcase
    endfunction

    function automatic int pick(bit [2:0] op);
        if (op == 3'b000 || op == 3'b010 || op == 3'b100) return 0;
        if (op == 3'b001) return 1;
        return 2;
    endfunction

    function automatic bit m_hiz();
        return (m_ir == 3'b000) || (m_ir == 3'b010);
    endfunction

    task automatic model_reset();
        m_st = 0; m_ir = 3'b001; m_irsh = '0; m_byp = 0; m_id = '0; m_bsr = '0;
        m_tdo = 0; m_oe = 0;
    endtask

    task automatic model_rise();
        int p = pick(m_ir);
        if (m_st == 10) m_irsh = 3'b001;
        if (m_st == 11) m_irsh = {tdi, m_irsh[2:1]};
        if (m_st == 3) begin
            if (p == 0) m_bsr = pad_in;
            else if (p == 1) m_id = IDV | 32'h1;
            else m_byp = 0;
        end
        if (m_st == 4) begin
            if (p == 0) m_bsr = {tdi, m_bsr[BW-1:1]};
            else if (p == 1) m_id = {tdi, m_id[31:1]};
            else m_byp = tdi;
        end
        m_st = nxt(m_st, tms);
    endtask

    task automatic model_fall();
        int p;
        if (m_st == 0)  m_ir = 3'b001;
        if (m_st == 15) m_ir = m_irsh;
        p = pick(m_ir);
        m_oe = (m_st == 4) || (m_st == 11);
        if (m_st == 11) m_tdo = m_irsh[0];
        else if (m_st == 4) m_tdo = (p == 0) ? m_bsr[0] : (p == 1) ? m_id[0] : m_byp;
    endtask

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One tck period: inputs set, rising edge, falling edge, compare
    task automatic step(bit m, bit d);
        tms = m; tdi = d;
        @(posedge tck); model_rise();
        @(negedge tck); model_fall();
        #2;
        chk(tdo_oe === m_oe, "R6", "tdo_oe", 32'(tdo_oe), 32'(m_oe));
        chk(data_hiz === m_hiz(), "R10", "data_hiz", 32'(data_hiz), 32'(m_hiz()));
        if (m_oe) begin
            chk(tdo === m_tdo, cur_req, "tdo", 32'(tdo), 32'(m_tdo));
            outq.push_back(tdo);
        end
    endtask

    // From run-test/idle, load an instruction; returns captured bits and hiz before update
    task automatic scan_ir(bit [2:0] op, output bit [2:0] cap, output bit hiz_pre);
        outq.delete();
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) step(i == 2, op[i]);
        hiz_pre = data_hiz;
        step(1, 0); step(0, 0);
        cap = '0;
        for (int i = 0; i < 3 && i < outq.size(); i++) cap[i] = outq[i];
    endtask

    task automatic scan_dr(int n, bit [31:0] din, bit pause_mid, output bit [31:0] dout);
        outq.delete();
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            bit brk = pause_mid && (i == 1) && (n > 2);
            step((i == n - 1) || brk, din[i]);
            if (brk) begin
                step(0, 0); step(0, 0); step(1, 0); step(0, 0);
            end
        end
        step(1, 0); step(0, 0);
        dout = '0;
        for (int i = 0; i < n && i < outq.size(); i++) dout[i] = outq[i];
        chk(outq.size() == n, cur_req, "shift count", 32'(outq.size()), 32'(n));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [2:0]  cap;
        bit        hz;
        bit [31:0] dout;
        model_reset();
        #55;
        // R3 / R6: reset state
        chk(tdo_oe === 1'b0, "R6", "reset tdo_oe", 32'(tdo_oe), 0);
        chk(data_hiz === 1'b0, "R3", "reset data_hiz", 32'(data_hiz), 0);
        @(negedge tck); #2; trst_n = 1;
        step(0, 0);

        // R3 / R8: default instruction is identification
        cur_req = "R8";
        scan_dr(32, 32'hFFFF_0000, 0, dout);
        chk(dout == (IDV | 32'h1), "R8", "id after reset", dout, IDV | 32'h1);

        // R4 / R7: bypass and the unused codes
        foreach (cap[i]) ;
        for (int k = 0; k < 4; k++) begin
            bit [2:0] op = (k == 0) ? 3'b111 : (k == 1) ? 3'b011 : (k == 2) ? 3'b101 : 3'b110;
            cur_req = "R4";
            scan_ir(op, cap, hz);
            chk(cap == 3'b001, "R4", "ir capture", 32'(cap), 1);
            cur_req = "R7";
            scan_dr(4, 32'hB, 0, dout);
            chk(dout[3:0] == 4'b0110, "R7", "bypass delay", dout, 32'h6);
            chk(data_hiz === 1'b0, "R10", "bypass hiz", 32'(data_hiz), 0);
        end

        // R9 / R11: sample without preload
        cur_req = "R9";
        pad_in = 5'b10110;
        scan_ir(3'b100, cap, hz);
        scan_dr(BW, 32'h1F, 0, dout);
        chk(dout[BW-1:0] == 5'b10110, "R9", "sample pads", dout, 32'h16);
        chk(data_hiz === 1'b0, "R11", "update-DR no hiz", 32'(data_hiz), 0);
        cur_req = "R1";
        pad_in = 5'b01101;
        scan_dr(BW, 32'h00, 1, dout);
        chk(dout[BW-1:0] == 5'b01101, "R11", "recapture after update", dout, 32'h0D);

        // R5 / R10: external test forces hiz only after Update-IR
        cur_req = "R5";
        scan_ir(3'b000, cap, hz);
        chk(hz === 1'b0, "R5", "hiz before update-IR", 32'(hz), 0);
        chk(data_hiz === 1'b1, "R10", "extest hiz", 32'(data_hiz), 1);
        cur_req = "R9";
        pad_in = 5'b11001;
        scan_dr(BW, 32'h0, 0, dout);
        chk(dout[BW-1:0] == 5'b11001, "R9", "extest pads", dout, 32'h19);
        scan_ir(3'b010, cap, hz);
        chk(data_hiz === 1'b1, "R10", "sample-z hiz", 32'(data_hiz), 1);
        pad_in = 5'b00111;
        scan_dr(BW, 32'h0, 0, dout);
        chk(dout[BW-1:0] == 5'b00111, "R9", "sample-z pads", dout, 32'h07);

        // R2: five highs from inside Shift-DR
        cur_req = "R2";
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk(data_hiz === 1'b0, "R2", "hiz after five highs", 32'(data_hiz), 0);
        step(0, 0);
        cur_req = "R3";
        scan_dr(32, 32'h0, 0, dout);
        chk(dout == (IDV | 32'h1), "R3", "id after tms reset", dout, IDV | 32'h1);

        // R2: five highs from Pause-IR
        scan_ir(3'b000, cap, hz);
        step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk(data_hiz === 1'b0, "R2", "hiz after escape from pause", 32'(data_hiz), 0);
        step(0, 0);

        // R2 / R6: asynchronous reset during Shift-DR
        scan_ir(3'b010, cap, hz);
        step(1, 0); step(0, 0); step(0, 0);
        chk(tdo_oe === 1'b1, "R6", "oe in shift", 32'(tdo_oe), 1);
        trst_n = 0; #1;
        chk(data_hiz === 1'b0, "R2", "async reset hiz", 32'(data_hiz), 0);
        chk(tdo_oe === 1'b0, "R6", "async reset oe", 32'(tdo_oe), 0);
        model_reset();
        #2; trst_n = 1;
        step(0, 0);
        chk(tdo_oe === 1'b0, "R6", "oe in idle", 32'(tdo_oe), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule